// File: doc/BRIEF.md
# Load-Use Interlock and Branch Squash Control

This block decides, every cycle, whether a scalar in-order five-stage pipeline (fetch, decode, execute, memory, writeback) may advance. It looks at the instruction sitting in the fetch/decode latch and the one in the decode/execute latch. Because the datapath forwards every result that is ready, the only dependence that cannot be covered is a load whose loaded value is needed by the very next instruction. In that case the fetch side is frozen for a cycle and an empty slot is pushed into execute.

Fetch always carries on sequentially, so every branch is in effect predicted not taken. When execute reports that a branch was taken, the two younger instructions already in flight are discarded and the program counter is steered to the target. The logic is purely combinational. It is re-evaluated from the latch contents every cycle and keeps no history of its own.

Top module: `pipe_interlock`

## Requirements
- R1: When the decode/execute opcode equals `OP_LOAD` (default 6'h20), its destination is non-zero and equals the first source of the fetch/decode instruction, the block stalls.
- R2: A match between the load's destination and the second source stalls only if the fetch/decode opcode is not `OP_STORE` (default 6'h28). For a store, that operand is the data to be written and no stall is raised.
- R3: A store whose first source (its address base) matches the load's destination still stalls.
- R4: During a stall, `pc_we` and `fd_we` are 0, `dx_bubble` is 1, and `fd_flush` and `pc_redirect` are 0.
- R5: A load whose destination is register 0 never causes a stall.
- R6: An instruction in decode/execute whose opcode is not `OP_LOAD` never causes a stall, whatever its register fields.
- R7: When `br_taken` is 1, `fd_flush`, `dx_bubble`, `pc_redirect`, `pc_we` and `fd_we` are all 1. The instructions in both younger slots are discarded, which costs two cycles.
- R8: A taken branch overrides a load-use stall that arises in the same cycle, and the outputs are exactly those of R7.
- R9: With no hazard and no taken branch, `pc_we` and `fd_we` are 1 and `dx_bubble`, `fd_flush` and `pc_redirect` are 0.
- R10: The outputs depend only on the present inputs. Once a hazard is removed from the inputs, the pipeline advances in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fd_op | input | OP_W | Opcode of the instruction in the fetch/decode latch |
| fd_rs1 | input | RA_W | First source register of the fetch/decode instruction |
| fd_rs2 | input | RA_W | Second source register of the fetch/decode instruction |
| dx_op | input | OP_W | Opcode of the instruction in the decode/execute latch |
| dx_rd | input | RA_W | Destination register of the decode/execute instruction |
| br_taken | input | 1 | Branch in execute resolved taken |
| pc_we | output | 1 | Program counter write enable |
| fd_we | output | 1 | Fetch/decode latch write enable |
| dx_bubble | output | 1 | Load a nop and cleared controls into decode/execute |
| fd_flush | output | 1 | Replace the fetch/decode contents with a nop |
| pc_redirect | output | 1 | Select the branch target as the next program counter |

## Verification
The embedded assertions are evaluated whenever the inputs change. They check the stall outputs for a first-source load hit, the store-data exemption, the register-0 exclusion, the absence of stalls behind non-loads, and the complete flush pattern under a taken branch, including when a stall would otherwise arise. Other properties only emerge across a sequence of cycles, and only the bench's scenarios can show them. These are that a stall lasts exactly one cycle before the dependent instruction moves on, that a taken branch removes precisely two younger slots, and that the stall and flush counts over a program match the reference pipeline occupancy.

// File: rtl/pipe_interlock.sv
module pipe_interlock #(
  parameter int OP_W = 6,
  parameter int RA_W = 5,
  parameter logic [OP_W-1:0] OP_LOAD  = 6'h20,
  parameter logic [OP_W-1:0] OP_STORE = 6'h28
) (
  input  logic [OP_W-1:0] fd_op,
  input  logic [RA_W-1:0] fd_rs1,
  input  logic [RA_W-1:0] fd_rs2,
  input  logic [OP_W-1:0] dx_op,
  input  logic [RA_W-1:0] dx_rd,
  input  logic            br_taken,
  output logic            pc_we,
  output logic            fd_we,
  output logic            dx_bubble,
  output logic            fd_flush,
  output logic            pc_redirect
);

  logic dx_load, dest_live, hit_a, hit_b, load_use;

  assign dx_load   = (dx_op == OP_LOAD);
  assign dest_live = (dx_rd != '0);
  assign hit_a     = (fd_rs1 == dx_rd);
  assign hit_b     = (fd_rs2 == dx_rd) && (fd_op != OP_STORE);
  assign load_use  = dx_load && dest_live && (hit_a || hit_b);

  assign fd_flush    = br_taken;
  assign pc_redirect = br_taken;
  assign dx_bubble   = br_taken || load_use;
  assign pc_we       = br_taken || !load_use;
  assign fd_we       = br_taken || !load_use;

  always_comb begin
    if (!br_taken && dx_op == OP_LOAD && dx_rd != '0 && dx_rd == fd_rs1)
      AST_LOAD_SRC1_STALL: assert (!pc_we && !fd_we && dx_bubble && !fd_flush) else $error("load-use stall missing"); // R1
    if (!br_taken && fd_op == OP_STORE && dx_rd != fd_rs1)
      AST_STORE_DATA_EXEMPT: assert (pc_we && fd_we && !dx_bubble) else $error("store data stalled"); // R2
    if (!br_taken && dx_rd == '0)
      AST_ZERO_DEST_FREE: assert (pc_we && fd_we && !dx_bubble) else $error("r0 caused stall"); // R5
    if (!br_taken && dx_op != OP_LOAD)
      AST_NONLOAD_FREE: assert (pc_we && fd_we && !dx_bubble) else $error("non-load stalled"); // R6
    if (br_taken)
      AST_FLUSH_WINS: assert (fd_flush && dx_bubble && pc_redirect && pc_we && fd_we) else $error("flush pattern wrong"); // R8
  end

endmodule

// File: tb/test_pipe_interlock.sv
module test_pipe_interlock;
  localparam logic [5:0] LD = 6'h20, ST = 6'h28, ALU = 6'h00, BR = 6'h04;
  localparam int PLEN = 18;

  typedef struct packed {
    logic [5:0] op;
    logic [4:0] rd, rs1, rs2;
    logic       tk;
    logic [7:0] tgt;
  } ins_t;

  logic clk = 0;
  always #4 clk = ~clk;

  logic [5:0] fd_op, dx_op;
  logic [4:0] fd_rs1, fd_rs2, dx_rd;
  logic br_taken;
  logic pc_we, fd_we, dx_bubble, fd_flush, pc_redirect;

  pipe_interlock i_pipe_interlock (
    .fd_op(fd_op), .fd_rs1(fd_rs1), .fd_rs2(fd_rs2),
    .dx_op(dx_op), .dx_rd(dx_rd), .br_taken(br_taken),
    .pc_we(pc_we), .fd_we(fd_we), .dx_bubble(dx_bubble),
    .fd_flush(fd_flush), .pc_redirect(pc_redirect));

  int tests = 0, fails = 0;
  ins_t prog [PLEN];
  ins_t fd, dx;
  int pc;
  int exp_stalls = 0, exp_flush = 0, dut_stalls = 0, dut_flush = 0;

  task automatic check(string tag, logic [4:0] got, logic [4:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%b exp=%b", tag, got, exp);
    end
  endtask

  function automatic ins_t mk(logic [5:0] op, logic [4:0] rd, logic [4:0] a, logic [4:0] b, logic tk, int tgt);
    ins_t i;
    i.op = op; i.rd = rd; i.rs1 = a; i.rs2 = b; i.tk = tk; i.tgt = tgt[7:0];
    return i;
  endfunction

  function automatic logic hazard(ins_t f, ins_t d);
    if (d.op != LD) return 1'b0;
    if (d.rd == 0) return 1'b0;
    if (f.rs1 == d.rd) return 1'b1;
    if (f.op == ST) return 1'b0;
    return (f.rs2 == d.rd);
  endfunction

  function automatic logic [4:0] expect_out(logic tk, logic hz);
    if (tk) return 5'b11111;
    if (hz) return 5'b00100;
    return 5'b11000;
  endfunction

  task automatic drive(ins_t f, ins_t d, logic tk);
    fd_op = f.op; fd_rs1 = f.rs1; fd_rs2 = f.rs2;
    dx_op = d.op; dx_rd = d.rd; br_taken = tk;
  endtask

  function automatic logic [4:0] outs();
    return {pc_we, fd_we, dx_bubble, fd_flush, pc_redirect};
  endfunction

  initial begin
    #(8 * 5000);
    fails++; tests++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    ins_t n, a, l;
    logic tk, hz;
    logic [4:0] e;
    prog[0]  = mk(ALU, 3, 1, 2, 0, 0);
    prog[1]  = mk(LD,  4, 3, 0, 0, 0);
    prog[2]  = mk(ALU, 5, 4, 1, 0, 0);
    prog[3]  = mk(LD,  6, 2, 0, 0, 0);
    prog[4]  = mk(ST,  0, 7, 6, 0, 0);
    prog[5]  = mk(LD,  8, 2, 0, 0, 0);
    prog[6]  = mk(ALU, 9, 1, 8, 0, 0);
    prog[7]  = mk(LD,  0, 1, 0, 0, 0);
    prog[8]  = mk(ALU, 2, 0, 0, 0, 0);
    prog[9]  = mk(LD, 10, 1, 0, 0, 0);
    prog[10] = mk(ST,  0, 10, 1, 0, 0);
    prog[11] = mk(BR,  0, 1, 0, 1, 14);
    prog[12] = mk(ALU, 13, 1, 1, 0, 0);
    prog[13] = mk(ALU, 14, 1, 1, 0, 0);
    prog[14] = mk(ALU, 11, 1, 2, 0, 0);
    prog[15] = mk(LD, 12, 1, 0, 0, 0);
    prog[16] = mk(BR,  0, 12, 0, 0, 0);
    prog[17] = mk(ALU, 15, 12, 12, 0, 0);
    n = '0;
    fd = n; dx = n; pc = 0;
    @(negedge clk);
    for (int c = 0; c < 40; c++) begin
      tk = (dx.op == BR) && dx.tk;
      hz = hazard(fd, dx);
      drive(fd, dx, tk);
      #1;
      e = expect_out(tk, hz);
      if (tk) begin check("R7 branch squash", outs(), e); exp_flush++; end
      else if (hz) begin check("R4 stall outputs", outs(), e); exp_stalls++; end
      else check("R9 free flow", outs(), e);
      if (dx_bubble && !fd_flush) dut_stalls++;
      if (fd_flush) dut_flush++;
      @(posedge clk);
      if (tk) begin
        pc = dx.tgt; fd = n; dx = n;
      end else if (hz) begin
        dx = n;
      end else begin
        dx = fd;
        fd = (pc < PLEN) ? prog[pc] : n;
        pc++;
      end
      @(negedge clk);
    end
    tests++;
    if (exp_stalls != 4 || dut_stalls != 4) begin
      fails++; $display("FAIL R1 stall count got=%0d exp=4 (model %0d)", dut_stalls, exp_stalls);
    end
    tests++;
    if (exp_flush != 1 || dut_flush != 1) begin
      fails++; $display("FAIL R7 flush count got=%0d exp=1 (model %0d)", dut_flush, exp_flush);
    end

    l = mk(LD, 5, 1, 0, 0, 0);
    a = mk(ALU, 6, 5, 2, 0, 0);
    drive(a, l, 0); #1; check("R1 src1 load-use", outs(), 5'b00100);
    a = mk(ALU, 6, 9, 9, 0, 0);
    drive(a, l, 0); #1; check("R10 hazard removed", outs(), 5'b11000);
    a = mk(ALU, 6, 2, 5, 0, 0);
    drive(a, l, 0); #1; check("R2 src2 non-store", outs(), 5'b00100);
    a = mk(ST, 0, 2, 5, 0, 0);
    drive(a, l, 0); #1; check("R2 store data exempt", outs(), 5'b11000);
    a = mk(ST, 0, 5, 2, 0, 0);
    drive(a, l, 0); #1; check("R3 store base", outs(), 5'b00100);
    a = mk(ALU, 6, 0, 0, 0, 0);
    drive(a, mk(LD, 0, 1, 0, 0, 0), 0); #1; check("R5 r0 dest", outs(), 5'b11000);
    a = mk(ALU, 6, 5, 5, 0, 0);
    drive(a, mk(ALU, 5, 1, 1, 0, 0), 0); #1; check("R6 non-load", outs(), 5'b11000);
    drive(a, l, 1); #1; check("R8 flush over stall", outs(), 5'b11111);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule